// File: doc/BRIEF.md
# Comb and Biquad Cascade Filter

A streaming, single-channel fixed-point filter. Each accepted input sample first passes a comb stage that subtracts a scaled copy of the sample taken a programmable number of samples earlier. It then passes a second-order recursive section. The overall response is (1 − c1·z^-N)·(b0 + b1·z^-1 + b2·z^-2)/(1/a0 − a1·z^-1 − a2·z^-2). The denominator's leading term is the reciprocal of a0, so a0 acts as a gain on the recursion. A single set of coefficients turns the block into a first difference, a running sum, a leaky integrator, a moving average or a feed-forward comb.

Samples enter on a valid/ready input and results leave on a valid/ready output, one result for each accepted sample. The result is registered and appears one cycle after acceptance. Coefficients and the delay count are plain inputs, sampled at the moment a sample is accepted. A synchronous clear empties the delay line, the recursive state and the pending result.

Top module: `comb_biquad_filter`

## Requirements
- R1: After reset, out_valid_o and ovf_o are low and in_ready_o is high.
- R2: With c1 = 0 the comb stage is transparent: with b0 = a0 = 1.0 and all other coefficients 0, each output equals its input. Coefficients are signed Q2.16, so 65536 is 1.0.
- R3: With delay_i = 0 the delayed sample is the current sample, so the comb output is (1 − c1)·x.
- R4: b0 = 1, b1 = −1, a0 = 1, the rest 0, gives y[n] = x[n] − x[n−1].
- R5: b0 = a0 = a1 = 1, the rest 0, gives y[n] = x[n] + y[n−1].
- R6: a0 = 1, a1 = 1 − α, b0 = α, the rest 0, gives y[n] = α·x[n] + (1 − α)·y[n−1].
- R7: c1 = 1, delay_i = 8, a0 = a1 = 1, b0 = 1/8 (8192) gives the mean of the last eight samples.
- R8: The recursion is w = a0·(v + a1·w1 + a2·w2), and w is held in 40 bits with 16 fractional bits. The output is rounded to nearest with halves rounded up and saturated to [−32768, 32767]. Any saturation sets ovf_o, which stays set until clear or reset.
- R9: clear_i zeroes the delay line, the recursive state, ovf_o and the pending result, and holds in_ready_o low while it is high.
- R10: Each accepted sample produces exactly one result, valid one cycle later. A result not taken is held stable, and in_ready_o is low while it waits.
- R11: A coefficient change applies from the next accepted sample on and leaves the stored state intact.
- R12: delay_i reaches 31, so the comb subtracts the sample from 31 acceptances earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all state |
| delay_i | input | 5 | Comb delay in samples, 0 to 31 |
| c1_i | input | 18 | Comb coefficient, Q2.16 |
| b0_i | input | 18 | Feed-forward tap 0, Q2.16 |
| b1_i | input | 18 | Feed-forward tap 1, Q2.16 |
| b2_i | input | 18 | Feed-forward tap 2, Q2.16 |
| a0_i | input | 18 | Recursion gain (reciprocal of the leading denominator term), Q2.16 |
| a1_i | input | 18 | Feedback tap 1, Q2.16 |
| a2_i | input | 18 | Feedback tap 2, Q2.16 |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample can be accepted |
| in_data_i | input | 16 | Input sample, two's complement |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result taken |
| out_data_o | output | 16 | Filtered result, two's complement |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The hardest state to reach is the far end of the delay line. Its contents only become visible when delay_i is 31 and 31 further samples have been accepted after the one of interest. The bench therefore sends a single impulse followed by a long zero run and checks the output both one sample before and exactly at the 31st step. The recursive corner at saturation is reached by running the integrator preset on a near-full-scale constant, which drives the output into both rails. Then the state is cleared, and a fresh sample shows that no stale state remains.

// File: rtl/cbq_pkg.sv
package cbq_pkg;
  localparam int CBQ_COEF_W = 18;
  localparam int CBQ_FRAC   = 16;

  typedef logic signed [CBQ_COEF_W-1:0] coef_t;

  typedef struct packed {
    coef_t c1;
    coef_t b0;
    coef_t b1;
    coef_t b2;
    coef_t a0;
    coef_t a1;
    coef_t a2;
  } coef_set_t;
endpackage

// File: rtl/cbq_comb.sv
module cbq_comb
  import cbq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int STATE_W   = 40,
  parameter int MAX_DELAY = 31,
  localparam int DLY_W    = $clog2(MAX_DELAY + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      accept_i,
  input  logic signed [DATA_W-1:0]  x_i,
  input  logic        [DLY_W-1:0]   delay_i,
  input  coef_t                     c1_i,
  output logic signed [STATE_W-1:0] v_o
);
  logic signed [DATA_W-1:0]  dline_q [MAX_DELAY];
  logic        [DLY_W-1:0]   tap_sel;
  logic signed [DATA_W-1:0]  x_dly;
  logic signed [STATE_W-1:0] x_scaled, c1_prod;

  // dline_q[k] holds x[n-1-k]
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_DELAY; k++) dline_q[k] <= '0;
    end else if (clear_i) begin
      for (int k = 0; k < MAX_DELAY; k++) dline_q[k] <= '0;
    end else if (accept_i) begin
      dline_q[0] <= x_i;
      for (int k = 1; k < MAX_DELAY; k++) dline_q[k] <= dline_q[k-1];
    end
  end

  // delay 0 selects the current sample (R3)
  always_comb begin
    tap_sel = (delay_i > DLY_W'(MAX_DELAY)) ? DLY_W'(MAX_DELAY) : delay_i;
    x_dly   = x_i;
    if (tap_sel != '0) x_dly = dline_q[tap_sel - DLY_W'(1)];
  end

  always_comb begin
    x_scaled = STATE_W'(x_i) <<< CBQ_FRAC;
    c1_prod  = STATE_W'(c1_i) * STATE_W'(x_dly);
    v_o      = x_scaled - c1_prod;
  end
endmodule

// File: rtl/cbq_biquad.sv
module cbq_biquad
  import cbq_pkg::*;
#(
  parameter int STATE_W = 40,
  localparam int WIDE_W = STATE_W + CBQ_COEF_W + 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      accept_i,
  input  logic signed [STATE_W-1:0] v_i,
  input  coef_set_t                 coef_i,
  output logic signed [WIDE_W-1:0]  acc_o,
  output logic                      wsat_o
);
  logic signed [STATE_W-1:0] w1_q, w2_q, w_new;
  logic signed [WIDE_W-1:0]  fb1, fb2, sum, gain, w_max, w_min;

  always_comb begin
    w_max = WIDE_W'({1'b0, {(STATE_W-1){1'b1}}});
    w_min = ~w_max;
    fb1   = (WIDE_W'(coef_i.a1) * WIDE_W'(w1_q)) >>> CBQ_FRAC;
    fb2   = (WIDE_W'(coef_i.a2) * WIDE_W'(w2_q)) >>> CBQ_FRAC;
    sum   = WIDE_W'(v_i) + fb1 + fb2;
    // a0 is the reciprocal of the leading denominator term
    gain  = (WIDE_W'(coef_i.a0) * sum) >>> CBQ_FRAC;
    wsat_o = 1'b0;
    if (gain > w_max) begin
      w_new  = STATE_W'(w_max);
      wsat_o = 1'b1;
    end else if (gain < w_min) begin
      w_new  = STATE_W'(w_min);
      wsat_o = 1'b1;
    end else begin
      w_new  = STATE_W'(gain);
    end
    acc_o = WIDE_W'(coef_i.b0) * WIDE_W'(w_new)
          + WIDE_W'(coef_i.b1) * WIDE_W'(w1_q)
          + WIDE_W'(coef_i.b2) * WIDE_W'(w2_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w1_q <= '0;
      w2_q <= '0;
    end else if (clear_i) begin
      w1_q <= '0;
      w2_q <= '0;
    end else if (accept_i) begin
      w2_q <= w1_q;
      w1_q <= w_new;
    end
  end
endmodule

// File: rtl/cbq_out.sv
module cbq_out
  import cbq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WIDE_W = 62,
  localparam int RND_SH = 2 * CBQ_FRAC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     accept_i,
  input  logic signed [WIDE_W-1:0] acc_i,
  input  logic                     wsat_i,
  input  logic                     out_ready_i,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] out_data_o,
  output logic                     ovf_o
);
  logic signed [WIDE_W-1:0] half, rounded, y_max, y_min;
  logic signed [DATA_W-1:0] y_sat;
  logic                     ysat;

  always_comb begin
    half             = '0;
    half[RND_SH-1]   = 1'b1;
    y_max            = WIDE_W'({1'b0, {(DATA_W-1){1'b1}}});
    y_min            = ~y_max;
    rounded          = (acc_i + half) >>> RND_SH;
    ysat             = 1'b1;
    if (rounded > y_max)      y_sat = DATA_W'(y_max);
    else if (rounded < y_min) y_sat = DATA_W'(y_min);
    else begin
      y_sat = DATA_W'(rounded);
      ysat  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      ovf_o       <= 1'b0;
    end else if (clear_i) begin
      out_valid_o <= 1'b0;
      ovf_o       <= 1'b0;
    end else begin
      if (accept_i) begin
        out_valid_o <= 1'b1;
        out_data_o  <= y_sat;
        if (ysat || wsat_i) ovf_o <= 1'b1;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/comb_biquad_filter.sv
module comb_biquad_filter
  import cbq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int STATE_W   = 40,
  parameter int MAX_DELAY = 31,
  localparam int DLY_W    = $clog2(MAX_DELAY + 1),
  localparam int WIDE_W   = STATE_W + CBQ_COEF_W + 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic [DLY_W-1:0]             delay_i,
  input  logic signed [CBQ_COEF_W-1:0] c1_i,
  input  logic signed [CBQ_COEF_W-1:0] b0_i,
  input  logic signed [CBQ_COEF_W-1:0] b1_i,
  input  logic signed [CBQ_COEF_W-1:0] b2_i,
  input  logic signed [CBQ_COEF_W-1:0] a0_i,
  input  logic signed [CBQ_COEF_W-1:0] a1_i,
  input  logic signed [CBQ_COEF_W-1:0] a2_i,
  input  logic                         in_valid_i,
  output logic                         in_ready_o,
  input  logic signed [DATA_W-1:0]     in_data_i,
  output logic                         out_valid_o,
  input  logic                         out_ready_i,
  output logic signed [DATA_W-1:0]     out_data_o,
  output logic                         ovf_o
);
  coef_set_t                 coef;
  logic                      accept;
  logic signed [STATE_W-1:0] comb_v;
  logic signed [WIDE_W-1:0]  acc;
  logic                      wsat;

  assign coef       = '{c1: c1_i, b0: b0_i, b1: b1_i, b2: b2_i,
                        a0: a0_i, a1: a1_i, a2: a2_i};
  assign in_ready_o = !clear_i && (!out_valid_o || out_ready_i);
  assign accept     = in_valid_i && in_ready_o;

  cbq_comb #(
    .DATA_W(DATA_W), .STATE_W(STATE_W), .MAX_DELAY(MAX_DELAY)
  ) u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .accept_i(accept),
    .x_i(in_data_i), .delay_i(delay_i), .c1_i(coef.c1), .v_o(comb_v)
  );

  cbq_biquad #(
    .STATE_W(STATE_W)
  ) u_biquad (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .accept_i(accept),
    .v_i(comb_v), .coef_i(coef), .acc_o(acc), .wsat_o(wsat)
  );

  cbq_out #(
    .DATA_W(DATA_W), .WIDE_W(WIDE_W)
  ) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .accept_i(accept),
    .acc_i(acc), .wsat_i(wsat), .out_ready_i(out_ready_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/cbq_checker.sv
module cbq_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              ovf_o
);
  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R10
  AST_NO_PHANTOM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) && out_ready_i |=> !out_valid_o); // R10
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !clear_i |=> out_valid_o && $stable(out_data_o)); // R10
  AST_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R10
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clear_i |=> ovf_o); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !out_valid_o && !ovf_o); // R9
  AST_CLEAR_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> !in_ready_o); // R9
endmodule

bind comb_biquad_filter cbq_checker #(.DATA_W(DATA_W)) u_cbq_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .ovf_o(ovf_o)
);

// File: tb/comb_biquad_filter_bench.sv
module comb_biquad_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint ONE = 65536;

  logic clk = 1'b0, rst_ni = 1'b0, clear = 1'b0;
  logic [4:0] dly = '0;
  logic signed [17:0] c1 = '0, b0 = '0, b1 = '0, b2 = '0, a0 = '0, a1 = '0, a2 = '0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, ovf;
  logic signed [15:0] in_data = '0, out_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  longint hx [32];
  longint w1 = 0, w2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comb_biquad_filter u_comb_biquad_filter (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear), .delay_i(dly),
    .c1_i(c1), .b0_i(b0), .b1_i(b1), .b2_i(b2), .a0_i(a0), .a1_i(a1), .a2_i(a2),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .ovf_o(ovf)
  );

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  function automatic longint satl(input longint v, input int w);
    longint mx = (64'sd1 <<< (w - 1)) - 1;
    if (v > mx) return mx;
    if (v < -mx - 1) return -mx - 1;
    return v;
  endfunction

  // reference from the requirement equations
  task automatic model(input int x, output longint y);
    longint xd, v, sm, g, w, acc, r;
    xd  = (dly == 0) ? longint'(x) : hx[dly - 1];
    v   = (longint'(x) <<< 16) - longint'(c1) * xd;
    sm  = v + ((longint'(a1) * w1) >>> 16) + ((longint'(a2) * w2) >>> 16);
    g   = (longint'(a0) * sm) >>> 16;
    w   = satl(g, 40);
    acc = longint'(b0) * w + longint'(b1) * w1 + longint'(b2) * w2;
    r   = (acc + (64'sd1 <<< 31)) >>> 32;
    y   = satl(r, 16);
    w2  = w1;
    w1  = w;
    for (int k = 31; k > 0; k--) hx[k] = hx[k-1];
    hx[0] = longint'(x);
  endtask

  task automatic model_reset();
    for (int k = 0; k < 32; k++) hx[k] = 0;
    w1 = 0;
    w2 = 0;
  endtask

  task automatic push(input int x, output longint got, output longint exp);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(x);
    model(x, exp);
    @(negedge clk);
    in_valid = 1'b0;
    got = longint'(out_data);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_reset();
  endtask

  task automatic set_coef(input longint c, input longint p0, input longint p1, input longint p2,
                          input longint q0, input longint q1, input longint q2, input int n);
    c1 = 18'(c); b0 = 18'(p0); b1 = 18'(p1); b2 = 18'(p2);
    a0 = 18'(q0); a1 = 18'(q1); a2 = 18'(q2); dly = 5'(n);
  endtask

  task automatic t_reset();
    check("R1 out_valid", longint'(out_valid), 0);
    check("R1 ovf", longint'(ovf), 0);
    check("R1 in_ready", longint'(in_ready), 1);
  endtask

  task automatic t_passthrough();
    int xs [5] = '{100, -200, 32767, -32768, 7};
    longint got, exp;
    do_clear();
    set_coef(0, ONE, 0, 0, ONE, 0, 0, 5);
    foreach (xs[i]) begin
      push(xs[i], got, exp);
      check("R2 passthrough", got, xs[i]);
      check("R10 one result", longint'(out_valid), 1);
    end
  endtask

  task automatic t_zero_delay();
    int xs [3] = '{101, -101, 1000};
    int ex [3] = '{51, -50, 500};
    longint got, exp;
    do_clear();
    set_coef(ONE / 2, ONE, 0, 0, ONE, 0, 0, 0);
    foreach (xs[i]) begin
      push(xs[i], got, exp);
      check("R3 zero delay", got, ex[i]);
    end
  endtask

  task automatic t_diff();
    int xs [4] = '{10, 30, 25, -5};
    int ex [4] = '{10, 20, -5, -30};
    longint got, exp;
    do_clear();
    set_coef(0, ONE, -ONE, 0, ONE, 0, 0, 3);
    foreach (xs[i]) begin
      push(xs[i], got, exp);
      check("R4 differencer", got, ex[i]);
    end
  endtask

  task automatic t_integ();
    int xs [3] = '{5, 5, -3};
    int ex [3] = '{5, 10, 7};
    longint got, exp;
    do_clear();
    set_coef(0, ONE, 0, 0, ONE, ONE, 0, 0);
    foreach (xs[i]) begin
      push(xs[i], got, exp);
      check("R5 integrator", got, ex[i]);
    end
  endtask

  task automatic t_leaky();
    longint got, exp;
    do_clear();
    set_coef(0, ONE / 4, 0, 0, ONE, 3 * ONE / 4, 0, 0);
    push(1000, got, exp);
    check("R6 leaky first", got, 250);
    for (int i = 0; i < 6; i++) begin
      push(1000, got, exp);
      check("R6 leaky", got, exp);
    end
  endtask

  task automatic t_mavg();
    longint got, exp;
    do_clear();
    set_coef(ONE, ONE / 8, 0, 0, ONE, ONE, 0, 8);
    for (int i = 1; i <= 14; i++) begin
      push(80, got, exp);
      check("R7 moving average", got, (i < 8) ? 10 * i : 80);
    end
  endtask

  task automatic t_long_comb();
    longint got, exp;
    do_clear();
    set_coef(ONE, ONE, 0, 0, ONE, 0, 0, 31);
    push(1000, got, exp);
    check("R12 impulse", got, 1000);
    for (int i = 1; i <= 31; i++) begin
      push(0, got, exp);
      if (i == 30) check("R12 before tap", got, 0);
      if (i == 31) check("R12 tap 31", got, -1000);
    end
  endtask

  task automatic t_saturate();
    longint got, exp;
    do_clear();
    set_coef(0, ONE, 0, 0, ONE, ONE, 0, 0);
    push(30000, got, exp);
    check("R8 no sat yet", got, 30000);
    check("R8 ovf low", longint'(ovf), 0);
    push(30000, got, exp);
    check("R8 pos sat", got, 32767);
    check("R8 ovf set", longint'(ovf), 1);
    push(-1, got, exp);
    check("R8 ovf sticky", longint'(ovf), 1);
    check("R8 model", got, exp);
    do_clear();
    check("R9 ovf cleared", longint'(ovf), 0);
    push(-30000, got, exp);
    push(-30000, got, exp);
    check("R8 neg sat", got, -32768);
  endtask

  task automatic t_clear();
    longint got, exp;
    do_clear();
    set_coef(0, ONE, 0, 0, ONE, ONE, 0, 4);
    push(700, got, exp);
    push(700, got, exp);
    @(negedge clk);
    clear    = 1'b1;
    in_valid = 1'b1;
    in_data  = 16'sd99;
    #1;
    check("R9 ready low in clear", longint'(in_ready), 0);
    @(negedge clk);
    clear    = 1'b0;
    in_valid = 1'b0;
    model_reset();
    check("R9 result dropped", longint'(out_valid), 0);
    push(5, got, exp);
    check("R9 state zeroed", got, 5);
  endtask

  task automatic t_stall();
    longint got, exp;
    do_clear();
    set_coef(0, ONE, 0, 0, ONE, 0, 0, 0);
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'sd7;
    model(7, exp);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 valid after accept", longint'(out_valid), 1);
    check("R10 backpressure", longint'(in_ready), 0);
    repeat (3) @(negedge clk);
    check("R10 held valid", longint'(out_valid), 1);
    check("R10 held data", longint'(out_data), 7);
    out_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", longint'(out_valid), 0);
    check("R10 ready back", longint'(in_ready), 1);
  endtask

  task automatic t_coef_change();
    longint got, exp;
    do_clear();
    set_coef(0, ONE, 0, 0, ONE, ONE, 0, 0);
    push(5, got, exp);
    check("R11 before change", got, 5);
    b0 = 18'(3 * ONE / 2);
    push(4, got, exp);
    check("R11 after change", got, 14);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_zero_delay();
    t_diff();
    t_integ();
    t_leaky();
    t_mavg();
    t_long_comb();
    t_saturate();
    t_clear();
    t_stall();
    t_coef_change();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule